// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is a sequential integer multiply and divide engine with its own pair of 32-bit result registers, HI and LO. It sits beside the general register file and takes instructions from the register-to-register group. The 6-bit function field selects the behaviour. The rs and rt operand values arrive already read from the register file.

A multiply or divide is accepted when `instValid` is high with one of the four arithmetic function codes and the unit is idle. The unit then iterates one bit per cycle for 32 cycles, holding `busy` high, and loads HI and LO at the end. Multiply writes the 64-bit product as upper half in HI and lower half in LO. Divide writes the quotient to LO and the remainder to HI.

The two move codes read HI or LO back on `rdData`, which the surrounding pipeline writes to the destination register. A move that arrives while an operation is still running raises `stall` instead, until the result has been loaded.

Top module: `mdu_hilo`

## Requirements
- R1: Function codes 24, 25, 26 and 27 start signed multiply, unsigned multiply, signed divide and unsigned divide. Any other code, except the two move codes, starts nothing and leaves HI and LO unchanged.
- R2: Signed multiply (code 24) loads the upper 32 bits of the signed 64-bit product rs*rt into HI and the lower 32 bits into LO.
- R3: Unsigned multiply (code 25) loads the upper 32 bits of the unsigned 64-bit product into HI and the lower 32 bits into LO.
- R4: Signed divide (code 26) puts the quotient rs/rt, truncated toward zero, in LO and the remainder, which takes the dividend's sign, in HI. 0x80000000 divided by -1 gives LO=0x80000000 and HI=0.
- R5: Unsigned divide (code 27) puts the unsigned quotient in LO and the unsigned remainder in HI.
- R6: A divide of either kind by zero completes normally, with LO set to all ones and HI set to the dividend.
- R7: `busy` rises on the clock edge that accepts a start and stays high for exactly 32 cycles. HI and LO change only on the edge where `busy` falls.
- R8: When idle, a move request with code 16 presents HI on `rdData` and code 18 presents LO, with `rdValid` high, in the same cycle.
- R9: A move request while `busy` is high drives `stall` high and `rdValid` low.
- R10: A start request while `busy` is high is ignored. The running operation keeps its operands and its completion time.
- R11: Synchronous reset clears HI, LO and `busy`, including in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction of this group is presented this cycle |
| funct | input | 6 | Function code of the presented instruction |
| rsData | input | 32 | Value of the rs operand |
| rtData | input | 32 | Value of the rt operand |
| busy | output | 1 | An operation is in progress |
| stall | output | 1 | A move request must wait for the running operation |
| rdValid | output | 1 | `rdData` carries a valid move result this cycle |
| rdData | output | 32 | HI or LO value for a move request |

## Verification
A wrong iteration count shows up as `busy` falling early or late. It also shows up as a product or quotient that is shifted, or missing its last bit, when HI and LO are read back immediately after completion. A wrong sign flag held across the 32 steps appears only at the final load, as a negated product, quotient or remainder. The vectors therefore cover every sign combination. A divide-by-zero flag that is lost, or an operand register overwritten by an ignored start, is seen on the first move after `busy` drops.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [5:0] FN_MFHI  = 6'd16;
  localparam logic [5:0] FN_MFLO  = 6'd18;
  localparam logic [5:0] FN_MULT  = 6'd24;
  localparam logic [5:0] FN_MULTU = 6'd25;
  localparam logic [5:0] FN_DIV   = 6'd26;
  localparam logic [5:0] FN_DIVU  = 6'd27;

  // low two bits of the arithmetic function codes map directly
  typedef enum logic [1:0] {OP_MULT, OP_MULTU, OP_DIV, OP_DIVU} mdOp_e;

  typedef struct packed {
    logic  load;
    logic  step;
    logic  finish;
    mdOp_e op;
  } mdStrobe_t;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       instValid,
  input  logic [5:0] funct,
  output mdStrobe_t  strb,
  output logic       busy,
  output logic       stall,
  output logic       rdValid,
  output logic       rdSelHi
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt;
  logic isArith, isMove, accept;

  always_comb begin
    isArith = instValid && (funct[5:2] == FN_MULT[5:2]);
    isMove  = instValid && (funct == FN_MFHI || funct == FN_MFLO);
    accept  = isArith && !busy;
    strb.load   = accept;
    strb.op     = mdOp_e'(funct[1:0]);
    strb.step   = busy;
    strb.finish = busy && (cnt == LAST);
    stall   = isMove && busy;
    rdValid = isMove && !busy;
    rdSelHi = (funct == FN_MFHI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  // R7: a new operation always begins its count from zero
  p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cnt == '0);
  // R7: the last step ends the operation
  p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST) |=> !busy);
  // R10: a start while busy does not restart or end the operation
  p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && isArith && cnt != LAST) |=> busy && cnt == $past(cnt) + 1'b1);
  // R9: stall and a valid read never appear together
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    stall |-> busy && !rdValid);
endmodule

// File: rtl/mdu_dpath.sv
module mdu_dpath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  mdStrobe_t        strb,
  input  logic [WIDTH-1:0] rsData,
  input  logic [WIDTH-1:0] rtData,
  input  logic             rdSelHi,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] hiReg, loReg, opA, divisor, workHi, workLo;
  logic [WIDTH-1:0] stepHi, stepLo, magA, magB;
  logic [WIDTH:0]   sum, remS, trial;
  logic [2*WIDTH-1:0] prod;
  mdOp_e opKind;
  logic  negMain, negRem, divZero, isSigned, aNeg, bNeg, isDivOp;

  always_comb begin
    isSigned = (strb.op == OP_MULT) || (strb.op == OP_DIV);
    aNeg = isSigned && rsData[WIDTH-1];
    bNeg = isSigned && rtData[WIDTH-1];
    magA = aNeg ? (~rsData + 1'b1) : rsData;
    magB = bNeg ? (~rtData + 1'b1) : rtData;
    isDivOp = (opKind == OP_DIV) || (opKind == OP_DIVU);
    // one multiply step: conditional add then shift the pair right
    sum   = {1'b0, workHi} + (workLo[0] ? {1'b0, divisor} : '0);
    // one restoring divide step: shift the pair left, try a subtract
    remS  = {workHi, workLo[WIDTH-1]};
    trial = remS - {1'b0, divisor};
    if (isDivOp) begin
      stepHi = trial[WIDTH] ? remS[WIDTH-1:0] : trial[WIDTH-1:0];
      stepLo = {workLo[WIDTH-2:0], ~trial[WIDTH]};
    end else begin
      stepHi = sum[WIDTH:1];
      stepLo = {sum[0], workLo[WIDTH-1:1]};
    end
    prod = {stepHi, stepLo};
    if (negMain) prod = ~prod + 1'b1;
    rdData = rdSelHi ? hiReg : loReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiReg <= '0;
      loReg <= '0;
      opA <= '0; divisor <= '0; workHi <= '0; workLo <= '0;
      opKind <= OP_MULT; negMain <= 1'b0; negRem <= 1'b0; divZero <= 1'b0;
    end else begin
      if (strb.load) begin
        opKind  <= strb.op;
        opA     <= rsData;
        divisor <= magB;
        workHi  <= '0;
        workLo  <= magA;
        negMain <= aNeg ^ bNeg;
        negRem  <= aNeg;
        divZero <= (rtData == '0);
      end else if (strb.step) begin
        workHi <= stepHi;
        workLo <= stepLo;
      end
      if (strb.finish) begin
        if (!isDivOp) begin
          hiReg <= prod[2*WIDTH-1:WIDTH];
          loReg <= prod[WIDTH-1:0];
        end else if (divZero) begin
          hiReg <= opA;
          loReg <= '1;
        end else begin
          loReg <= negMain ? (~stepLo + 1'b1) : stepLo;
          hiReg <= negRem ? (~stepHi + 1'b1) : stepHi;
        end
      end
    end
  end

  // R7: result registers move only at completion
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.finish |=> $stable(hiReg) && $stable(loReg));
  // R10: captured operand survives every step of the operation
  p_opnd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    strb.step |=> $stable(opA));
  // R6: divide by zero yields all ones and the dividend
  p_divzero_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.finish && divZero && isDivOp) |=> loReg == '1 && hiReg == $past(opA));
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] rsData,
  input  logic [WIDTH-1:0] rtData,
  output logic             busy,
  output logic             stall,
  output logic             rdValid,
  output logic [WIDTH-1:0] rdData
);
  mdStrobe_t strb;
  logic rdSelHi;

  mdu_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rst(rst), .instValid(instValid), .funct(funct),
    .strb(strb), .busy(busy), .stall(stall), .rdValid(rdValid),
    .rdSelHi(rdSelHi)
  );

  mdu_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk(clk), .rst(rst), .strb(strb), .rsData(rsData), .rtData(rtData),
    .rdSelHi(rdSelHi), .rdData(rdData)
  );
endmodule

// File: tb/mdu_hilo_tb.sv
`timescale 1ns/1ps
module mdu_hilo_tb_top;
  logic clk = 1'b0, rst = 1'b1, instValid = 1'b0;
  logic [5:0] funct = '0;
  logic [31:0] rsData = '0, rtData = '0;
  logic busy, stall, rdValid;
  logic [31:0] rdData;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mdu_hilo dut_i (.clk(clk), .rst(rst), .instValid(instValid), .funct(funct),
    .rsData(rsData), .rtData(rtData), .busy(busy), .stall(stall),
    .rdValid(rdValid), .rdData(rdData));

  typedef struct packed { logic [5:0] f; logic [31:0] a; logic [31:0] b; } vec_t;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{6'd24, 32'd3, 32'd5},
    '{6'd24, 32'hFFFFFFFD, 32'd5},
    '{6'd24, 32'h80000000, 32'h80000000},
    '{6'd25, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{6'd25, 32'h12345678, 32'h9ABCDEF0},
    '{6'd26, 32'd7, 32'd2},
    '{6'd26, 32'hFFFFFFF9, 32'd2},
    '{6'd26, 32'd7, 32'hFFFFFFFE},
    '{6'd26, 32'h80000000, 32'hFFFFFFFF},
    '{6'd27, 32'hFFFFFFFF, 32'd3},
    '{6'd27, 32'd100, 32'd7},
    '{6'd26, 32'd5, 32'd0},
    '{6'd27, 32'hFFFFFFF0, 32'd0},
    '{6'd26, 32'hFFFFFFF7, 32'd0}
  };

  function automatic logic [63:0] model(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    logic signed [63:0] sa, sb, q, r;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (f)
      6'd24: model = sa * sb;
      6'd25: model = {32'd0, a} * {32'd0, b};
      6'd26: if (b == 0) model = {a, 32'hFFFFFFFF};
             else begin q = sa / sb; r = sa % sb; model = {r[31:0], q[31:0]}; end
      default: if (b == 0) model = {a, 32'hFFFFFFFF};
               else model = {a % b, a / b};
    endcase
  endfunction

  function automatic string tagOf(logic [5:0] f, logic [31:0] b);
    if (f == 6'd24) tagOf = "R2";
    else if (f == 6'd25) tagOf = "R3";
    else if (b == 0) tagOf = "R6";
    else if (f == 6'd26) tagOf = "R4";
    else tagOf = "R5";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // move request in the low clock phase; returns data, rdValid and stall
  task automatic readMove(logic [5:0] f, output logic [31:0] d, output logic v, output logic s);
    instValid = 1'b1; funct = f;
    #1 d = rdData; v = rdValid; s = stall;
    instValid = 1'b0;
  endtask

  task automatic readHiLo(string tag, logic [63:0] exp);
    logic [31:0] d; logic v, s;
    readMove(6'd16, d, v, s);
    check({tag, " HI (R8 code 16)"}, {d, 31'd0, v}, {exp[63:32], 32'd1});
    readMove(6'd18, d, v, s);
    check({tag, " LO (R8 code 18)"}, {d, 31'd0, v}, {exp[31:0], 32'd1});
  endtask

  // issue an op and follow busy for 32 cycles; optionally probe mid-run
  task automatic runOp(logic [5:0] f, logic [31:0] a, logic [31:0] b, bit probe);
    int bad = 0;
    logic [31:0] d; logic v, s;
    @(negedge clk); instValid = 1'b1; funct = f; rsData = a; rtData = b;
    @(negedge clk); instValid = 1'b0;
    rsData = 32'h0BADF00D; rtData = 32'h00000001;
    check("R7 busy after start", {63'd0, busy}, 64'd1);
    for (int k = 1; k < 32; k++) begin
      @(negedge clk);
      if (probe && k == 6) instValid = 1'b0;
      if (busy !== 1'b1) bad++;
      if (probe && k == 5) begin
        readMove(6'd16, d, v, s);
        check("R9 stall while busy", {62'd0, s, v}, 64'd2);
        instValid = 1'b1; funct = 6'd25;   // R10 start while busy
      end
    end
    check("R7 busy held 32 cycles", 64'(bad), 64'd0);
    @(negedge clk);
    check("R7 busy falls after 32", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    logic [31:0] d; logic v, s;
    logic [63:0] last;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 busy after reset", {63'd0, busy}, 64'd0);
    readHiLo("R11 reset", 64'd0);

    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].f, VECS[i].a, VECS[i].b, i == 1);
      readHiLo(tagOf(VECS[i].f, VECS[i].b), model(VECS[i].f, VECS[i].a, VECS[i].b));
    end
    last = model(VECS[NV-1].f, VECS[NV-1].a, VECS[NV-1].b);

    // R1: code 20 starts nothing
    @(negedge clk); instValid = 1'b1; funct = 6'd20; rsData = 32'd9; rtData = 32'd9;
    @(negedge clk); instValid = 1'b0;
    check("R1 code 20 no start", {63'd0, busy}, 64'd0);
    readHiLo("R1 code 20 unchanged", last);

    // R10 explicit: result after an ignored start equals the first op
    runOp(6'd25, 32'd1000, 32'd1000, 1'b1);
    readHiLo("R10 ignored start", 64'd1000000);

    // R11: reset in the middle of an operation
    @(negedge clk); instValid = 1'b1; funct = 6'd24; rsData = 32'd77; rtData = 32'd77;
    @(negedge clk); instValid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 busy cleared mid-op", {63'd0, busy}, 64'd0);
    readMove(6'd16, d, v, s);
    check("R11 HI cleared", {32'd0, d}, 64'd0);
    readMove(6'd18, d, v, s);
    check("R11 LO cleared", {32'd0, d}, 64'd0);
    repeat (40) @(negedge clk);
    check("R11 no late load", {63'd0, busy}, 64'd0);
    readHiLo("R11 after idle", 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule